// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers the event indications of a three-phase metering front end into one 16-bit word of sticky flags. Sag detectors, zero-crossing timeout detectors, rising zero-crossing detectors, two peak comparators, a line-cycle accumulation sequencer, a waveform sampler and a reset indication each deliver a one-cycle pulse. Two energy accumulators deliver only their most significant bit. The block watches that bit for a 0-to-1 edge, which marks the accumulator as half full. Each event sets its own flag. The flag stays at 1 until software clears it.

A 16-bit mask register selects which flags may pull the active-low interrupt line. Software uses a small read/write port. One address returns the flag word and leaves it as it is. A second address returns the same word and clears every flag in that same access. A third address holds the mask. An event that lands in the same cycle as a clearing read is kept, so no event is lost.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset every flag is 0, the mask register reads 0 and irq_n is 1.
- R2: Each event sets exactly its own flag bit, using this map: bit 0 is the active-energy MSB edge (acc_msb[0]); bits 3:1 are sag on phases A, B and C; bits 6:4 are zero-crossing timeout on A, B and C; bits 9:7 are rising zero crossing on A, B and C; bit 10 is line-cycle end; bit 11 is the reset event; bit 12 is the voltage peak; bit 13 is the current peak; bit 14 is a new waveform sample; bit 15 is the apparent-energy MSB edge (acc_msb[1]).
- R3: A set flag stays at 1 after its event input returns to 0. Flags gather until they are cleared.
- R4: A read at address 0x10 returns the flag word on rdata in the same cycle and does not change any flag.
- R5: A read at address 0x11 returns the flag word in the same cycle, and from the next cycle on every flag is 0.
- R6: An event that arrives in the same cycle as a read at 0x11 leaves its flag at 1 after the clear. The data of that read shows the word from before the clear.
- R7: A half-full flag sets only on a 0-to-1 change of its accumulator MSB. If the MSB stays at 1 after the flag is cleared, the flag does not set again.
- R8: An accumulator MSB that is already 1 when reset is released does not set a half-full flag.
- R9: A write at address 0x12 loads the mask, and a read there returns it. irq_n is 0 exactly when some flag is 1 and its mask bit is also 1.
- R10: A flag whose mask bit is 0 still sets and can still be read, and it leaves irq_n at 1.
- R11: A read at any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_sag | input | 3 | Sag pulses, phases A/B/C on bits 0/1/2 |
| evt_zxto | input | 3 | Zero-crossing timeout pulses, phases A/B/C |
| evt_zx | input | 3 | Rising zero-crossing pulses, phases A/B/C |
| evt_lcyc | input | 1 | End of line-cycle accumulation pulse |
| evt_rst | input | 1 | Reset-occurred pulse |
| evt_vpeak | input | 1 | Voltage peak over threshold pulse |
| evt_ipeak | input | 1 | Current peak over threshold pulse |
| evt_wave | input | 1 | New waveform sample pulse |
| acc_msb | input | 2 | MSBs of the active (bit 0) and apparent (bit 1) energy accumulators |
| rd_en | input | 1 | Read strobe for the register port |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 8 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid in the cycle of rd_en |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its default parameters: an 8-bit address, the three addresses 0x10, 0x11 and 0x12, and a 16-bit word. A word that small lets the bench drive every one of the 16 event sources on its own, with the expected word computed as a shift of one. It also steps a one-hot mask through every bit position against both a matching flag and a non-matching flag. Together these cover every pairing of flag and mask bit that decides irq_n. Directed cases then cover the event that collides with a clear, an MSB held high through reset, and an MSB held high across a clear.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int STAT_W    = 16;
  localparam int NUM_PHASE = 3;
  localparam int NUM_ACC   = 2;

  localparam int B_AEHF  = 0;
  localparam int B_SAG   = 1;
  localparam int B_ZXTO  = B_SAG + NUM_PHASE;
  localparam int B_ZX    = B_ZXTO + NUM_PHASE;
  localparam int B_LCYC  = B_ZX + NUM_PHASE;
  localparam int B_RST   = B_LCYC + 1;
  localparam int B_VPK   = B_RST + 1;
  localparam int B_IPK   = B_VPK + 1;
  localparam int B_WAVE  = B_IPK + 1;
  localparam int B_VAEHF = B_WAVE + 1;

  typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/isc_msb_edge.sv
module isc_msb_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] msb,
  output logic [N-1:0] rise
);
  logic         armed_q, armed_d;
  logic [N-1:0] msb_q, msb_d;

  always_comb begin
    armed_d = 1'b1;
    msb_d   = msb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      msb_q   <= '0;
    end else begin
      armed_q <= armed_d;
      msb_q   <= msb_d;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_edge
    assign rise[g] = armed_q & msb[g] & ~msb_q[g];
  end
endmodule

// File: rtl/isc_flag_bank.sv
module isc_flag_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr,
  output logic [W-1:0] flags
);
  logic [W-1:0] flag_q, flag_d;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_comb begin
      flag_d[g] = set_vec[g] | (flag_q[g] & ~clr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flags = flag_q;
endmodule

// File: rtl/isc_read_mux.sv
module isc_read_mux #(
  parameter int          W           = 16,
  parameter int          ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] CLEAR_ADDR  = 8'h11,
  parameter logic [ADDR_W-1:0] MASK_ADDR   = 8'h12
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      flags,
  input  logic [W-1:0]      mask,
  output logic [W-1:0]      rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == STATUS_ADDR || addr == CLEAR_ADDR) rdata = flags;
      else if (addr == MASK_ADDR)                    rdata = mask;
    end
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] CLEAR_ADDR  = 8'h11,
  parameter logic [ADDR_W-1:0] MASK_ADDR   = 8'h12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [isc_pkg::NUM_PHASE-1:0] evt_sag,
  input  logic [isc_pkg::NUM_PHASE-1:0] evt_zxto,
  input  logic [isc_pkg::NUM_PHASE-1:0] evt_zx,
  input  logic                      evt_lcyc,
  input  logic                      evt_rst,
  input  logic                      evt_vpeak,
  input  logic                      evt_ipeak,
  input  logic                      evt_wave,
  input  logic [isc_pkg::NUM_ACC-1:0] acc_msb,
  input  logic                      rd_en,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [isc_pkg::STAT_W-1:0] wdata,
  output logic [isc_pkg::STAT_W-1:0] rdata,
  output logic                      irq_n
);
  import isc_pkg::*;

  localparam int NP = NUM_PHASE;

  logic [NUM_ACC-1:0] acc_rise;
  stat_t set_vec, flag_q, mask_q, mask_d;
  logic  clr, mask_we;

  isc_msb_edge #(.N(NUM_ACC)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .msb  (acc_msb),
    .rise (acc_rise)
  );

  always_comb begin
    set_vec                 = '0;
    set_vec[B_AEHF]         = acc_rise[0];
    set_vec[B_SAG  +: NP]   = evt_sag;
    set_vec[B_ZXTO +: NP]   = evt_zxto;
    set_vec[B_ZX   +: NP]   = evt_zx;
    set_vec[B_LCYC]         = evt_lcyc;
    set_vec[B_RST]          = evt_rst;
    set_vec[B_VPK]          = evt_vpeak;
    set_vec[B_IPK]          = evt_ipeak;
    set_vec[B_WAVE]         = evt_wave;
    set_vec[B_VAEHF]        = acc_rise[1];
  end

  assign clr     = rd_en & (addr == CLEAR_ADDR);
  assign mask_we = wr_en & (addr == MASK_ADDR);

  isc_flag_bank #(.W(STAT_W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(set_vec),
    .clr    (clr),
    .flags  (flag_q)
  );

  always_comb begin
    mask_d = mask_q;
    if (mask_we) mask_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  isc_read_mux #(
    .W(STAT_W), .ADDR_W(ADDR_W),
    .STATUS_ADDR(STATUS_ADDR), .CLEAR_ADDR(CLEAR_ADDR), .MASK_ADDR(MASK_ADDR)
  ) u_rd (
    .rd_en(rd_en),
    .addr (addr),
    .flags(flag_q),
    .mask (mask_q),
    .rdata(rdata)
  );

  assign irq_n = ~|(flag_q & mask_q);
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] CLEAR_ADDR  = 8'h11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        acc_msb,
  input logic              irq_n,
  input logic [15:0]       flags,
  input logic [15:0]       mask,
  input logic [15:0]       set_vec
);
  logic clr_rd, stat_rd;
  assign clr_rd  = rd_en && addr == CLEAR_ADDR;
  assign stat_rd = rd_en && addr == STATUS_ADDR;

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_rd |=> ((flags & $past(flags)) == $past(flags)));

  assert_status_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && set_vec == '0) |=> $stable(flags));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd && set_vec == '0) |=> flags == '0);

  assert_collide_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rd |=> flags == $past(set_vec));

  assert_halffull_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(acc_msb[0]));

  assert_halffull_va_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[15]) |-> $past(acc_msb[1]));

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(irq_n) |-> (!$stable(flags) || !$stable(mask)));
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(
  .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .CLEAR_ADDR(CLEAR_ADDR)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rd_en  (rd_en),
  .addr   (addr),
  .acc_msb(acc_msb),
  .irq_n  (irq_n),
  .flags  (flag_q),
  .mask   (mask_q),
  .set_vec(set_vec)
);

// File: tb/irq_status_ctrl_test.sv
`timescale 1ns/1ps
module irq_status_ctrl_test;
  localparam logic [7:0] A_STAT = 8'h10, A_CLR = 8'h11, A_MASK = 8'h12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] evt_sag = '0, evt_zxto = '0, evt_zx = '0;
  logic evt_lcyc = 1'b0, evt_rst = 1'b0, evt_vpeak = 1'b0, evt_ipeak = 1'b0, evt_wave = 1'b0;
  logic [1:0] acc_msb = 2'b11;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic irq_n;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_status_ctrl uut (
    .clk(clk), .rst_n(rst_n), .evt_sag(evt_sag), .evt_zxto(evt_zxto), .evt_zx(evt_zx),
    .evt_lcyc(evt_lcyc), .evt_rst(evt_rst), .evt_vpeak(evt_vpeak), .evt_ipeak(evt_ipeak),
    .evt_wave(evt_wave), .acc_msb(acc_msb), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_src(int i, logic v);
    case (i)
      1, 2, 3:    evt_sag[i-1]  = v;
      4, 5, 6:    evt_zxto[i-4] = v;
      7, 8, 9:    evt_zx[i-7]   = v;
      10: evt_lcyc  = v;
      11: evt_rst   = v;
      12: evt_vpeak = v;
      13: evt_ipeak = v;
      14: evt_wave  = v;
      0:  acc_msb[0] = v;
      default: acc_msb[1] = v;
    endcase
  endtask

  // drives one event; the flag is set after the first step
  task automatic pulse(int i);
    set_src(i, 1'b1); step(); set_src(i, 1'b0); step();
  endtask

  task automatic rd(logic [7:0] a, string req, logic [15:0] exp);
    rd_en = 1'b1; addr = a; #1;
    check(req, rdata, exp);
    step(); rd_en = 1'b0;
  endtask

  task automatic wr_mask(logic [15:0] v);
    wr_en = 1'b1; addr = A_MASK; wdata = v; step(); wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;                       // MSBs held at 1 across release
    repeat (3) step();
    check("R1 irq_n after reset", {15'd0, irq_n}, 16'd1);
    rd(A_STAT, "R1/R8 flags after reset", 16'h0000);
    rd(A_MASK, "R1 mask after reset", 16'h0000);
    acc_msb = 2'b00; step();

    for (int i = 0; i < 16; i++) begin
      pulse(i);
      rd(A_STAT, "R2 single event map", 16'(1) << i);
      check("R10 masked flag leaves irq_n high", {15'd0, irq_n}, 16'd1);
      rd(A_STAT, "R4 status read keeps flags", 16'(1) << i);
      rd(A_CLR, "R5 clearing read data", 16'(1) << i);
      rd(A_STAT, "R5 flags after clear", 16'h0000);
    end

    for (int i = 0; i < 16; i++) pulse(i);
    rd(A_STAT, "R3 flags accumulate", 16'hFFFF);

    for (int i = 0; i < 16; i++) begin
      wr_mask(16'(1) << i);
      check("R9 one-hot mask with all flags", {15'd0, irq_n}, 16'd0);
    end
    rd(A_MASK, "R9 mask readback", 16'h8000);
    rd(A_CLR, "R5 clear all", 16'hFFFF);

    for (int i = 0; i < 16; i++) begin
      wr_mask(16'(1) << i);
      pulse((i + 5) % 16);
      check("R10 non-matching flag irq_n", {15'd0, irq_n}, 16'd1);
      rd(A_STAT, "R10 masked flag readable", 16'(1) << ((i + 5) % 16));
      pulse(i);
      check("R9 matching flag irq_n", {15'd0, irq_n}, 16'd0);
      rd(A_CLR, "R5 clear pair", (16'(1) << i) | (16'(1) << ((i + 5) % 16)));
      check("R9 irq_n after clear", {15'd0, irq_n}, 16'd1);
    end

    // collision of event and clear
    pulse(1);
    set_src(3, 1'b1);
    rd(A_CLR, "R6 read shows pre-clear word", 16'h0002);
    set_src(3, 1'b0);
    rd(A_STAT, "R6 colliding event kept", 16'h0008);
    rd(A_CLR, "R6 cleanup", 16'h0008);

    // MSB held high across a clear
    acc_msb[1] = 1'b1; step();
    rd(A_CLR, "R7 rising MSB sets bit 15", 16'h8000);
    repeat (4) step();
    rd(A_STAT, "R7 held MSB does not re-set", 16'h0000);
    acc_msb[1] = 1'b0; step();
    acc_msb[1] = 1'b1; step();
    rd(A_STAT, "R7 second rise sets bit 15", 16'h8000);
    acc_msb[1] = 1'b0;
    rd(A_CLR, "R7 cleanup", 16'h8000);

    rd(8'h20, "R11 unmapped address", 16'h0000);
    rd(8'h00, "R11 unmapped address zero", 16'h0000);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule